// File: doc/BRIEF.md
# Double-Buffered Sprite Blitter

This unit owns two RGB332 pixel surfaces. One is shown (the front surface) and the other is drawn into (the back surface). A CPU-side writer drives it through byte-wide port writes: a port select plus a data byte. Two ports load the X and Y coordinate registers. Three ports start drawing: plot one pixel, copy an 8x8 sprite from memory, or flood the whole back surface with one colour. The last port exchanges front and back. Pixels are 8-bit RGB332 values stored as opaque bytes. In the chip the surface is 160 by 128. The `SURF_W`/`SURF_H` parameters carry that size, and their defaults are a reduced 40 by 24.

Sprite copies read 64 bytes in row-major order from a 16-bit base address through a request/valid memory port, with one request outstanding at a time. When memory answers in the cycle after each request, one pixel is written per cycle. While a clear or sprite copy runs, `busy` is high. Port writes made while busy are dropped, so the writer must wait for `busy` to fall. Pixels landing outside the surface are skipped, never wrapped. A read-back port returns any pixel of either surface one cycle after its coordinates are presented.

The controller has four states. IDLE accepts port writes. CLEAR steps a linear counter over every pixel. SPR_START issues the first sprite fetch. SPR_WAIT writes each returned byte and issues the next fetch. The transitions are:
- IDLE->CLEAR on a clear command.
- IDLE->SPR_START on a sprite command.
- CLEAR->IDLE after the last pixel.
- SPR_START->SPR_WAIT unconditionally.
- SPR_WAIT->IDLE when byte 63 arrives.

Top module: `gfx_blit_top`

## Requirements
- R1: After reset `busy` is 0, `front_idx` is 0, `mem_req` is 0, and both coordinate registers are 0.
- R2: A write with `port_sel`=0 loads X and a write with `port_sel`=1 loads Y from `port_data`; later draw commands use these coordinates.
- R3: A write with `port_sel`=2 stores `port_data` at (X,Y) in the back surface within one cycle. It leaves the front surface unchanged and does not raise `busy`.
- R4: A pixel command with X >= SURF_W or Y >= SURF_H changes no pixel of either surface.
- R5: A write with `port_sel`=3 fetches exactly 64 bytes from `sprite_base`+0 through `sprite_base`+63 in ascending order, one `mem_req` per byte.
- R6: Sprite byte k is stored in the back surface at (X + k mod 8, Y + k div 8).
- R7: Sprite pixels with a coordinate beyond the surface are skipped; the remaining sprite pixels are still drawn.
- R8: When each fetch is answered in the following cycle, `busy` stays high for exactly 65 cycles after a sprite command.
- R9: A write with `port_sel`=4 fills every back-surface pixel with `port_data`, holds `busy` high for exactly SURF_W*SURF_H cycles, and leaves the front surface untouched.
- R10: A write with `port_sel`=5 toggles `front_idx` in the next cycle without raising `busy`; the former back surface becomes the front.
- R11: Port writes of any kind issued while `busy` is high are ignored.
- R12: `view_pixel` shows, one cycle after `view_back`/`view_x`/`view_y` are presented, the pixel at that position (`view_back`=1 selects the back surface, 0 the front).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Port write strobe |
| port_sel | input | 3 | Port select: 0 X, 1 Y, 2 pixel, 3 sprite, 4 clear, 5 swap |
| port_data | input | 8 | Port write data (coordinate or RGB332 colour) |
| sprite_base | input | 16 | Sprite source address, sampled with the sprite command |
| busy | output | 1 | High while a clear or sprite copy is running |
| front_idx | output | 1 | Index of the surface currently shown |
| mem_req | output | 1 | Sprite byte fetch request |
| mem_addr | output | 16 | Sprite byte fetch address |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 8 | Fetch data |
| view_back | input | 1 | Read-back surface select: 1 back, 0 front |
| view_x | input | 8 | Read-back X |
| view_y | input | 8 | Read-back Y |
| view_pixel | output | 8 | Read-back pixel, one cycle later; 0 off-surface |

## Verification
The X and Y loads, pixel plots and swaps take effect at the accepting edge. The bench therefore drives at a falling edge and samples surface state through read-back at the next falling edges. Read-back data is due one edge after the coordinates are presented, and each read samples exactly there. `busy` is counted from the first falling edge after the accepting edge until it drops, and the count must be SURF_W*SURF_H for a clear and 65 for a sprite copy with next-cycle memory. Fetch order is logged at each rising edge that carries a request and compared once the copy ends.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
    typedef enum logic [2:0] {
        PORT_X      = 3'd0,
        PORT_Y      = 3'd1,
        PORT_PIXEL  = 3'd2,
        PORT_SPRITE = 3'd3,
        PORT_CLEAR  = 3'd4,
        PORT_SWAP   = 3'd5
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SPR_START,
        ST_SPR_WAIT
    } blit_state_e;

    localparam int SPR_SIDE  = 8;
    localparam int SPR_BYTES = SPR_SIDE * SPR_SIDE;
endpackage

// File: rtl/gfx_surface.sv
module gfx_surface #(
    parameter int SURF_W = 40,
    parameter int SURF_H = 24,
    localparam int DEPTH  = SURF_W * SURF_H,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbuf,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              rbuf,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] pix [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wbuf == 1'(b)) pix[waddr] <= wdata;
        end
        assign bank_rd[b] = pix[raddr];
    end

    always_ff @(posedge clk) begin
        rdata <= rd_ok ? bank_rd[rbuf] : 8'h00;
        if (we) begin
            a_r4_waddr_in_surface: assert (int'(waddr) < DEPTH);
        end
    end
endmodule

// File: rtl/gfx_blit_fsm.sv
module gfx_blit_fsm
    import gfx_pkg::*;
#(
    parameter int SURF_W = 40,
    parameter int SURF_H = 24,
    localparam int DEPTH  = SURF_W * SURF_H,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = (ADDR_W > 6) ? ADDR_W : 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [2:0]        port_sel,
    input  logic [7:0]        port_data,
    input  logic [15:0]       sprite_base,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              front_idx,
    output logic              mem_req,
    output logic [15:0]       mem_addr,
    output logic              fb_we,
    output logic              fb_wbuf,
    output logic [ADDR_W-1:0] fb_waddr,
    output logic [7:0]        fb_wdata
);
    localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(DEPTH - 1);
    localparam logic [5:0]       SPR_LAST = 6'(SPR_BYTES - 1);

    blit_state_e       state_q, state_d;
    logic [7:0]        x_q, y_q, color_q;
    logic [15:0]       base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              front_q;
    logic              accept;
    logic [8:0]        spr_px, spr_py;

    assign accept = port_wr && (state_q == ST_IDLE);
    assign spr_px = {1'b0, x_q} + {6'd0, cnt_q[2:0]};
    assign spr_py = {1'b0, y_q} + {6'd0, cnt_q[5:3]};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && port_sel == PORT_CLEAR)  state_d = ST_CLEAR;
                if (accept && port_sel == PORT_SPRITE) state_d = ST_SPR_START;
            end
            ST_CLEAR:     if (cnt_q == CLR_LAST) state_d = ST_IDLE;
            ST_SPR_START: state_d = ST_SPR_WAIT;
            ST_SPR_WAIT:  if (mem_rvalid && cnt_q[5:0] == SPR_LAST) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            x_q     <= '0;
            y_q     <= '0;
            color_q <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            front_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
                if (port_sel == PORT_X)      x_q     <= port_data;
                if (port_sel == PORT_Y)      y_q     <= port_data;
                if (port_sel == PORT_CLEAR)  color_q <= port_data;
                if (port_sel == PORT_SPRITE) base_q  <= sprite_base;
                if (port_sel == PORT_SWAP)   front_q <= ~front_q;
            end
            if (state_q == ST_CLEAR) cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_SPR_WAIT && mem_rvalid) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        fb_we    = 1'b0;
        fb_waddr = '0;
        fb_wdata = '0;
        mem_req  = 1'b0;
        mem_addr = base_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && port_sel == PORT_PIXEL &&
                    int'(x_q) < SURF_W && int'(y_q) < SURF_H) begin
                    fb_we    = 1'b1;
                    fb_waddr = ADDR_W'(int'(y_q) * SURF_W + int'(x_q));
                    fb_wdata = port_data;
                end
            end
            ST_CLEAR: begin
                fb_we    = 1'b1;
                fb_waddr = ADDR_W'(cnt_q);
                fb_wdata = color_q;
            end
            ST_SPR_START: begin
                mem_req  = 1'b1;
                mem_addr = base_q;
            end
            ST_SPR_WAIT: begin
                if (mem_rvalid) begin
                    if (int'(spr_px) < SURF_W && int'(spr_py) < SURF_H) begin
                        fb_we    = 1'b1;
                        fb_waddr = ADDR_W'(int'(spr_py) * SURF_W + int'(spr_px));
                        fb_wdata = mem_rdata;
                    end
                    mem_req  = (cnt_q[5:0] != SPR_LAST);
                    mem_addr = base_q + 16'(cnt_q[5:0]) + 16'd1;
                end
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign front_idx = front_q;
    assign fb_wbuf   = ~front_q;

    a_r11_coords_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(x_q) && $stable(y_q)));
    a_r11_front_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(front_q));
    a_r5_fetch_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - base_q) < 16'(SPR_BYTES)));
endmodule

// File: rtl/gfx_blit_top.sv
module gfx_blit_top #(
    parameter int SURF_W = 40,
    parameter int SURF_H = 24,
    localparam int DEPTH  = SURF_W * SURF_H,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_wr,
    input  logic [2:0]  port_sel,
    input  logic [7:0]  port_data,
    input  logic [15:0] sprite_base,
    output logic        busy,
    output logic        front_idx,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [7:0]  mem_rdata,
    input  logic        view_back,
    input  logic [7:0]  view_x,
    input  logic [7:0]  view_y,
    output logic [7:0]  view_pixel
);
    logic              fb_we, fb_wbuf;
    logic [ADDR_W-1:0] fb_waddr, view_addr;
    logic [7:0]        fb_wdata;
    logic              view_ok;

    assign view_ok   = int'(view_x) < SURF_W && int'(view_y) < SURF_H;
    assign view_addr = view_ok ? ADDR_W'(int'(view_y) * SURF_W + int'(view_x)) : '0;

    gfx_blit_fsm #(.SURF_W(SURF_W), .SURF_H(SURF_H)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_wr    (port_wr),
        .port_sel   (port_sel),
        .port_data  (port_data),
        .sprite_base(sprite_base),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .front_idx  (front_idx),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fb_we      (fb_we),
        .fb_wbuf    (fb_wbuf),
        .fb_waddr   (fb_waddr),
        .fb_wdata   (fb_wdata)
    );

    gfx_surface #(.SURF_W(SURF_W), .SURF_H(SURF_H)) u_surface (
        .clk  (clk),
        .we   (fb_we),
        .wbuf (fb_wbuf),
        .waddr(fb_waddr),
        .wdata(fb_wdata),
        .rbuf (view_back ? ~front_idx : front_idx),
        .rd_ok(view_ok),
        .raddr(view_addr),
        .rdata(view_pixel)
    );

    a_r8_busy_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(port_wr));
    a_r10_swap_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
        (front_idx != $past(front_idx)) |-> $past(port_wr));
endmodule

// File: tb/tb_gfx_blit_top.sv
`timescale 1ns/1ps
module tb_gfx_blit_top;
    localparam int W = 40;
    localparam int H = 24;
    localparam int N = W * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_wr = 1'b0;
    logic [2:0]  port_sel = '0;
    logic [7:0]  port_data = '0;
    logic [15:0] sprite_base = '0;
    logic        busy, front_idx, mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        view_back = 1'b0;
    logic [7:0]  view_x = '0, view_y = '0;
    logic [7:0]  view_pixel;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [2][N];
    logic [7:0] cur_x = 0, cur_y = 0;
    logic       model_front = 1'b0;

    // memory responder
    logic        slow = 1'b0;
    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0;
    logic [15:0] req_log [128];
    int          req_total = 0;

    always #2 clk = ~clk;

    gfx_blit_top #(.SURF_W(W), .SURF_H(H)) dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_sel(port_sel),
        .port_data(port_data), .sprite_base(sprite_base), .busy(busy),
        .front_idx(front_idx), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .view_back(view_back),
        .view_x(view_x), .view_y(view_y), .view_pixel(view_pixel)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] + 8'h3C) ^ a[15:8];
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            req_log[req_total[6:0]] <= mem_addr;
            req_total <= req_total + 1;
            if (slow) begin
                pend <= 1'b1;
                pend_addr <= mem_addr;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata <= pat(mem_addr);
            end
        end else if (pend) begin
            pend <= 1'b0;
            mem_rvalid <= 1'b1;
            mem_rdata <= pat(pend_addr);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic port(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        port_wr = 1'b1; port_sel = sel; port_data = d;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic view(input logic bk, input int x, input int y, output logic [7:0] v);
        @(negedge clk);
        view_back = bk; view_x = 8'(x); view_y = 8'(y);
        @(negedge clk);
        v = view_pixel;
    endtask

    // compare one surface (by index) against the model
    task automatic compare_surface(input string req, input logic idx);
        logic [7:0] v;
        int bad = 0;
        logic [7:0] a0 = 0, e0 = 0;
        for (int i = 0; i < N; i++) begin
            view(idx != front_idx, i % W, i / W, v);
            if (v !== model[idx][i]) begin
                if (bad == 0) begin a0 = v; e0 = model[idx][i]; end
                bad++;
            end
        end
        check(req, {24'd0, a0}, {24'd0, e0});
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_clear(input logic [7:0] c, input string req);
        int n;
        port(3'd4, c);
        count_busy(n);
        check(req, n, N);
        for (int i = 0; i < N; i++) model[~model_front][i] = c;
    endtask

    task automatic do_sprite(input logic [15:0] base, output int n);
        int start;
        sprite_base = base;
        start = req_total;
        port(3'd3, 8'h00);
        count_busy(n);
        repeat (2) @(negedge clk);
        check("R5 request count", req_total - start, 64);
        begin
            int bad = 0;
            for (int k = 0; k < 64; k++)
                if (req_log[(start + k) % 128] !== base + 16'(k)) bad++;
            check("R5 request order", bad, 0);
        end
        for (int k = 0; k < 64; k++) begin
            int px = int'(cur_x) + k % 8;
            int py = int'(cur_y) + k / 8;
            if (px < W && py < H) model[~model_front][py * W + px] = pat(base + 16'(k));
        end
    endtask

    localparam logic [23:0] PIX_VEC [8] = '{
        {8'd0,  8'd0,  8'hA1}, {8'd39, 8'd0,  8'hB2},
        {8'd0,  8'd23, 8'hC3}, {8'd39, 8'd23, 8'hD4},
        {8'd17, 8'd9,  8'hE5}, {8'd17, 8'd9,  8'hF6},
        {8'd1,  8'd22, 8'h07}, {8'd38, 8'd1,  8'h18}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 front_idx", front_idx, 0);
        check("R1 mem_req", mem_req, 0);

        // R9 clear back surface 1, then swap and clear surface 0
        do_clear(8'h11, "R9 clear busy cycles");
        compare_surface("R9 clear fills back", 1'b1);
        port(3'd5, 8'h00);
        model_front = 1'b1;
        check("R10 front toggled", front_idx, 1);
        check("R10 no busy on swap", busy, 0);
        view(1'b0, 5, 5, v);
        check("R10 old back now front", v, 8'h11);
        do_clear(8'h22, "R9 clear busy cycles 2");
        compare_surface("R9 clear fills back 2", 1'b0);
        compare_surface("R9 front untouched by clear", 1'b1);

        // R2 R3 pixel table
        for (int i = 0; i < 8; i++) begin
            logic [7:0] px, py, c;
            {px, py, c} = PIX_VEC[i];
            port(3'd0, px); cur_x = px;
            port(3'd1, py); cur_y = py;
            port(3'd2, c);
            check("R3 no busy on pixel", busy, 0);
            model[~model_front][int'(py) * W + int'(px)] = c;
            view(1'b1, px, py, v);
            check("R2 R3 pixel at X,Y", v, c);
        end
        compare_surface("R3 back after pixels", 1'b0);
        compare_surface("R3 front unchanged by pixels", 1'b1);

        // R4 off-surface pixel: X=W would wrap into (0,1) if not skipped
        port(3'd0, 8'(W)); port(3'd1, 8'd0); port(3'd2, 8'h99);
        port(3'd0, 8'd3);  port(3'd1, 8'(H)); port(3'd2, 8'h9A);
        compare_surface("R4 off-surface pixel ignored back", 1'b0);
        compare_surface("R4 off-surface pixel ignored front", 1'b1);

        // R12 read-back latency: two different pixels back to back
        @(negedge clk);
        view_back = 1'b1; view_x = 8'd0; view_y = 8'd0;
        @(negedge clk);
        v = view_pixel;
        view_x = 8'd39; view_y = 8'd0;
        @(negedge clk);
        v2 = view_pixel;
        check("R12 readback first", v, 8'hA1);
        check("R12 readback second", v2, 8'hB2);

        // R5 R6 R8 sprite with next-cycle memory
        port(3'd0, 8'd5); cur_x = 5;
        port(3'd1, 8'd3); cur_y = 3;
        do_sprite(16'h1234, n);
        check("R8 sprite busy cycles", n, 65);
        compare_surface("R6 sprite placement", 1'b0);

        // R7 clipped sprite with slow memory
        slow = 1'b1;
        port(3'd0, 8'(W - 3)); cur_x = 8'(W - 3);
        port(3'd1, 8'(H - 2)); cur_y = 8'(H - 2);
        do_sprite(16'hFFE0, n);
        slow = 1'b0;
        compare_surface("R7 clipped sprite", 1'b0);
        compare_surface("R7 front untouched", 1'b1);

        // R11 writes during busy are dropped
        port(3'd0, 8'd1); cur_x = 1;
        port(3'd1, 8'd1); cur_y = 1;
        @(negedge clk);
        port_wr = 1'b1; port_sel = 3'd4; port_data = 8'h33;
        @(negedge clk);
        port_sel = 3'd0; port_data = 8'd30;
        @(negedge clk);
        port_sel = 3'd2; port_data = 8'h77;
        @(negedge clk);
        port_sel = 3'd5; port_data = 8'h00;
        @(negedge clk);
        port_wr = 1'b0;
        count_busy(n);
        for (int i = 0; i < N; i++) model[~model_front][i] = 8'h33;
        check("R11 front not swapped during busy", front_idx, 1);
        compare_surface("R11 pixel during busy ignored", 1'b0);
        port(3'd2, 8'h55);
        model[~model_front][1 * W + 1] = 8'h55;
        view(1'b1, 1, 1, v);
        check("R11 X kept during busy", v, 8'h55);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule